// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block keeps one processor's small direct-mapped write-back cache coherent with its peers on a shared snooping bus. Every line carries one of four coherence states: Invalid, Shared, Exclusive and Modified. The processor side serves reads, writes and read-for-ownership requests. Hits complete in the cycle they are presented. Misses and ownership upgrades become bus transactions: read, read-exclusive, invalidate, and writeback of a dirty victim.

The bus side watches transactions from other caches. For a snooped read that hits a valid line, the controller asserts the wired shared-response output. If the line is dirty it also raises a writeback flag and presents the line data, so that memory is updated before the line drops to Shared. A snooped read-exclusive or invalidate removes the local copy.

When this controller issues its own bus read, it samples the shared-response input in the single cycle that follows the address cycle. That sample decides whether the filled line becomes Exclusive or Shared. An Exclusive line can later be written with no bus traffic. Each line holds one data word.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `bus_valid` and `cpu_ack` are low, and a snooped read asserts neither `snp_shared` nor `snp_wb`.
- R2: A read miss with the shared-response input low issues a bus read (`bus_cmd` 0), returns the reply data with `cpu_ack`, and installs the line as Exclusive.
- R3: A read miss with the shared-response input high installs the line as Shared. A later write hit to it issues an invalidate (`bus_cmd` 2) and leaves the line Modified.
- R4: The shared-response input is sampled only in the cycle right after the bus read address cycle. A high level only in a later cycle of that transaction still yields Exclusive.
- R5: A write hit on an Exclusive or Modified line completes in one cycle with no bus transaction and leaves the line Modified.
- R6: A write miss issues read-exclusive (`bus_cmd` 1) and installs the line Modified, holding the written word.
- R7: A read-for-ownership request (`cpu_op` 2) that misses, or that hits a Shared line, issues read-exclusive and installs the reply data as Exclusive, even when a peer supplies that data. On an Exclusive or Modified hit it completes with no bus transaction.
- R8: A snooped read (`snp_cmd` 0) that hits an Exclusive or Shared line asserts `snp_shared` and presents the unchanged data with `snp_wb` low. The line becomes Shared.
- R9: A snooped read that hits a Modified line asserts both `snp_shared` and `snp_wb`, presents the dirty data, and leaves the line Shared.
- R10: A snooped read-exclusive (`snp_cmd` 1) or invalidate (`snp_cmd` 2) that hits a valid line makes it Invalid. A read-exclusive that hits a Modified line also asserts `snp_wb` with the data.
- R11: A miss that evicts a Modified line first issues a writeback (`bus_cmd` 3) of the old address and data, then the fill. Evicting an Exclusive or Shared line issues no writeback.
- R12: A snoop to an Invalid line or to a different tag gives no response and leaves the cached line unchanged.
- R13: A read hit returns the cached word with `cpu_ack` in the cycle the request is presented, with no bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_op | input | 2 | 0 read, 1 write, 2 read-for-ownership |
| cpu_addr | input | ADDR_W | Word address; low bits index the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | Request complete this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` |
| bus_valid | output | 1 | Own bus transaction active, held until `bus_ack` |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_rdata | input | DATA_W | Reply data, valid with `bus_ack` |
| bus_shared_in | input | 1 | Wired shared-response line as seen by this cache |
| snp_valid | input | 1 | Another cache's transaction is on the bus this cycle |
| snp_cmd | input | 2 | Snooped command, same coding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache drives the shared-response line |
| snp_wb | output | 1 | Dirty data on `snp_data` must update memory |
| snp_data | output | DATA_W | Line data for a snoop hit |

## Verification
The bench builds the block with four lines, a six-bit address and sixteen-bit data. With a two-bit index, addresses such as 0x05 and 0x09 compete for one line. Each eviction case (dirty writeback, silent clean drop) can then be reached in a few requests, and the bench can model the whole 64-word memory directly. A bus model stalls every transaction for three cycles. This gives the shared-response sampling cycle and a later cycle apart from each other, so a response in the wrong cycle can be told apart from one in the right cycle.

// File: rtl/mesi_pkg.sv
// Shared encodings for the coherence controller.
// Assumes: the 2-bit command coding is common to the issued and snooped buses.
package mesi_pkg;
    typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
    typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_INV = 2'd2, BC_WB = 2'd3} bus_cmd_t;
    localparam logic [1:0] OP_RD  = 2'd0;
    localparam logic [1:0] OP_WR  = 2'd1;
    localparam logic [1:0] OP_RFO = 2'd2;
endpackage

// File: rtl/mesi_line_store.sv
// Per-line state, tag and data registers with two read ports (processor, snoop)
// and two write ports. Assumes: a snoop write takes priority over a processor
// write to the same line; only the processor port writes tag and data.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 12,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_t          a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_t          b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              sw_en,
    input  line_st_t          sw_state,
    input  logic              cw_en,
    input  logic [TAG_W-1:0]  cw_tag,
    input  logic [DATA_W-1:0] cw_data,
    input  line_st_t          cw_state
);
    line_st_t          st_q   [NUM_LINES];
    logic [TAG_W-1:0]  tag_q  [NUM_LINES];
    logic [DATA_W-1:0] data_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Coherence state: reset to Invalid, snoop update wins over processor update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st_q[g] <= LN_I;
            else if (sw_en && b_idx == IDX_W'(g))
                st_q[g] <= sw_state;
            else if (cw_en && a_idx == IDX_W'(g))
                st_q[g] <= cw_state;
        end
        // Tag and data: written only by the processor side on fill or write.
        always_ff @(posedge clk) begin
            if (cw_en && a_idx == IDX_W'(g)) begin
                tag_q[g]  <= cw_tag;
                data_q[g] <= cw_data;
            end
        end
    end

    // Read ports: asynchronous lookup for both sides.
    always_comb begin
        a_state = st_q[a_idx];
        a_tag   = tag_q[a_idx];
        a_data  = data_q[a_idx];
        b_state = st_q[b_idx];
        b_tag   = tag_q[b_idx];
        b_data  = data_q[b_idx];
    end
endmodule

// File: rtl/mesi_snoop_unit.sv
// Combinational snoop responder: decides the shared-response, the dirty
// writeback flag and the new line state for a transaction from another cache.
// Assumes: snoops arrive only while this cache has no bus transaction open.
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 12,
    parameter int DATA_W = 32
) (
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_t          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              shared_out,
    output logic              wb_out,
    output logic [DATA_W-1:0] data_out,
    output logic              upd_en,
    output line_st_t          upd_state
);
    logic hit;

    // Response and state change for one snooped command.
    always_comb begin
        hit        = snp_valid && line_state != LN_I && line_tag == snp_tag;
        shared_out = 1'b0;
        wb_out     = 1'b0;
        upd_en     = 1'b0;
        upd_state  = LN_I;
        data_out   = hit ? line_data : '0;
        if (hit) begin
            unique case (bus_cmd_t'(snp_cmd))
                BC_RD: begin
                    shared_out = 1'b1;
                    wb_out     = line_state == LN_M;
                    upd_en     = 1'b1;
                    upd_state  = LN_S;
                end
                BC_RDX: begin
                    wb_out = line_state == LN_M;
                    upd_en = 1'b1;
                end
                BC_INV: upd_en = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mesi_req_fsm.sv
// Processor-side sequencer: serves hits at once, otherwise writes back a dirty
// victim, issues the fill or upgrade, samples the shared response one cycle
// after the address cycle, and installs the line. Assumes: cpu inputs stay
// stable until cpu_ack; a hit is deferred while a snoop is active.
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    input  line_st_t          line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    input  logic              snp_busy,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] wr_data,
    output line_st_t          wr_state
);
    typedef enum logic [2:0] {F_IDLE, F_WB, F_ADDR, F_RESP, F_FILL} fsm_t;

    fsm_t       st_q, st_n;
    bus_cmd_t   cmd_q, cmd_n;
    logic       shr_q, shr_n;
    logic       hit, fin, fin_shr, start;
    bus_cmd_t   go_cmd;
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] idx;

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= F_IDLE;
            cmd_q <= BC_RD;
            shr_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            cmd_q <= cmd_n;
            shr_q <= shr_n;
        end
    end

    // Next state, bus drive and line update.
    always_comb begin
        tag       = cpu_addr[ADDR_W-1:IDX_W];
        idx       = cpu_addr[IDX_W-1:0];
        hit       = line_state != LN_I && line_tag == tag;
        st_n      = st_q;
        cmd_n     = cmd_q;
        shr_n     = shr_q;
        start     = 1'b0;
        go_cmd    = BC_RD;
        fin       = 1'b0;
        fin_shr   = 1'b0;
        cpu_ack   = 1'b0;
        cpu_rdata = '0;
        bus_valid = 1'b0;
        bus_cmd   = BC_RD;
        bus_addr  = cpu_addr;
        bus_wdata = '0;
        wr_en     = 1'b0;
        wr_tag    = tag;
        wr_data   = cpu_wdata;
        wr_state  = LN_M;
        unique case (st_q)
            F_IDLE: if (cpu_req && !snp_busy) begin
                if (cpu_op == OP_WR) begin
                    if (hit && line_state != LN_S) begin
                        wr_en   = 1'b1;
                        cpu_ack = 1'b1;
                    end else begin
                        start  = 1'b1;
                        go_cmd = hit ? BC_INV : BC_RDX;
                    end
                end else if (cpu_op == OP_RFO) begin
                    if (hit && line_state != LN_S) begin
                        cpu_ack   = 1'b1;
                        cpu_rdata = line_data;
                    end else begin
                        start  = 1'b1;
                        go_cmd = BC_RDX;
                    end
                end else if (hit) begin
                    cpu_ack   = 1'b1;
                    cpu_rdata = line_data;
                end else begin
                    start  = 1'b1;
                    go_cmd = BC_RD;
                end
                if (start) begin
                    cmd_n = go_cmd;
                    st_n  = (!hit && line_state == LN_M) ? F_WB : F_ADDR;
                end
            end
            F_WB: begin
                bus_valid = 1'b1;
                bus_cmd   = BC_WB;
                bus_addr  = {line_tag, idx};
                bus_wdata = line_data;
                if (bus_ack) st_n = F_ADDR;
            end
            F_ADDR: begin
                bus_valid = 1'b1;
                bus_cmd   = cmd_q;
                st_n      = F_RESP;
            end
            F_RESP: begin
                bus_valid = 1'b1;
                bus_cmd   = cmd_q;
                shr_n     = bus_shared_in;
                fin_shr   = bus_shared_in;
                fin       = bus_ack;
                if (!bus_ack) st_n = F_FILL;
            end
            F_FILL: begin
                bus_valid = 1'b1;
                bus_cmd   = cmd_q;
                fin_shr   = shr_q;
                fin       = bus_ack;
            end
            default: st_n = F_IDLE;
        endcase
        if (fin) begin
            st_n    = F_IDLE;
            wr_en   = 1'b1;
            cpu_ack = 1'b1;
            if (cpu_op == OP_WR) begin
                wr_state = LN_M;
            end else begin
                wr_data   = bus_rdata;
                cpu_rdata = bus_rdata;
                wr_state  = (cpu_op == OP_RFO) ? LN_E : (fin_shr ? LN_S : LN_E);
            end
        end
    end
endmodule

// File: rtl/mesi_snoop_cache.sv
// Top of the coherence controller: joins the line store, the snoop responder
// and the processor-side sequencer. Assumes: the bus never presents a snoop
// while this cache's own transaction is open.
module mesi_snoop_cache
    import mesi_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 16,
    localparam int IDX_W    = $clog2(NUM_LINES),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [1:0]        cpu_op,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_wb,
    output logic [DATA_W-1:0] snp_data
);
    line_st_t          a_state, b_state, sw_state, cw_state;
    logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
    logic [DATA_W-1:0] a_data, b_data, cw_data;
    logic              sw_en, cw_en;

    mesi_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cpu_addr[IDX_W-1:0]), .a_state(a_state), .a_tag(a_tag), .a_data(a_data),
        .b_idx(snp_addr[IDX_W-1:0]), .b_state(b_state), .b_tag(b_tag), .b_data(b_data),
        .sw_en(sw_en), .sw_state(sw_state),
        .cw_en(cw_en), .cw_tag(cw_tag), .cw_data(cw_data), .cw_state(cw_state)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
        .line_state(b_state), .line_tag(b_tag), .line_data(b_data),
        .shared_out(snp_shared), .wb_out(snp_wb), .data_out(snp_data),
        .upd_en(sw_en), .upd_state(sw_state)
    );

    mesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .line_state(a_state), .line_tag(a_tag), .line_data(a_data),
        .snp_busy(snp_valid),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
        .wr_en(cw_en), .wr_tag(cw_tag), .wr_data(cw_data), .wr_state(cw_state)
    );
endmodule

// File: rtl/mesi_snoop_cache_chk.sv
// Protocol checker for the coherence controller, attached by bind.
// Assumes: inputs are driven to known values from time zero.
module mesi_snoop_cache_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ack,
    input logic              bus_valid,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_shared,
    input logic              snp_wb
);
    // R1: the first cycle out of reset is quiet on the bus and processor side.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !bus_valid && !cpu_ack);

    // R4: an open transaction keeps command and address until acknowledged.
    p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ack |=> bus_valid && $stable(bus_cmd) && $stable(bus_addr));

    // R11: a writeback of a victim is followed at once by the fill or upgrade.
    p_fill_after_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_cmd == 2'd3 && bus_ack |=> bus_valid && bus_cmd != 2'd3);

    // R9: after a snooped read hit, a repeated snooped read sees a clean shared copy.
    p_clean_after_share_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_cmd == 2'd0 && $past(snp_valid && snp_cmd == 2'd0 && snp_shared)
        && snp_addr == $past(snp_addr) |-> snp_shared && !snp_wb);

    // R10: after a snooped read-exclusive or invalidate, the same address gives no response.
    p_gone_after_inv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && $past(snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2))
        && snp_addr == $past(snp_addr) |-> !snp_shared && !snp_wb);

    // R13: a completion is only given to a pending request.
    p_ack_needs_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_req);
endmodule

bind mesi_snoop_cache mesi_snoop_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mesi_snoop_cache.sv
`timescale 1ns/1ps
// Bench for the coherence controller: a table of processor requests with
// expected data and bus traffic, then directed snoop and corner-case tests.
module sim_mesi_snoop_cache;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          bus_valid;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared;
    logic          snp_wb;
    logic [DW-1:0] snp_data;

    mesi_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .NUM_LINES(NL)) u0 (.*);

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] mem [64];
    int shr_mode = 0;          // 0 never, 1 in response cycle, 2 only in a later cycle
    logic peer_give = 1'b0;
    logic [DW-1:0] peer_val = '0;
    int txn_cnt = 0;
    logic [1:0] last_cmd = 2'd0;
    logic [AW-1:0] wb_addr = '0;
    logic [DW-1:0] wb_data = '0;
    int bcnt = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Memory and peer model: acknowledges every transaction in its third cycle.
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack = 1'b0;
            bus_shared_in = 1'b0;
            bcnt = 0;
        end
        if (bus_valid) begin
            bcnt++;
            if (bcnt == 2 && shr_mode == 1 && bus_cmd == 2'd0) bus_shared_in = 1'b1;
            if (bcnt == 3) begin
                bus_shared_in = (shr_mode == 2);
                bus_ack = 1'b1;
                txn_cnt++;
                last_cmd = bus_cmd;
                if (bus_cmd == 2'd3) begin
                    mem[bus_addr] = bus_wdata;
                    wb_addr = bus_addr;
                    wb_data = bus_wdata;
                end
                bus_rdata = (bus_cmd == 2'd1 && peer_give) ? peer_val : mem[bus_addr];
            end
        end
    end

    task automatic cpu_do(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd, output int ntx, output int cyc);
        int t0;
        logic got;
        t0 = txn_cnt;
        cpu_op = op; cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
        cyc = 0;
        rd = '0;
        do begin
            #1;
            cyc++;
            got = cpu_ack;
            if (got) rd = cpu_rdata;
            @(negedge clk);
        end while (!got);
        cpu_req = 1'b0;
        ntx = txn_cnt - t0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                         output logic sh, output logic wb, output logic [DW-1:0] dat);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1;
        sh = snp_shared; wb = snp_wb; dat = snp_data;
        if (wb) mem[a] = dat;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1 actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    // Vector fields: {req, op, addr, wdata, shared, exp_data, exp_txn, exp_last}
    localparam int NV = 11;
    localparam logic [48:0] VEC [NV] = '{
        {4'd2,  2'd0, 6'h05, 16'h0000, 1'b0, 16'h1005, 2'd1, 2'd0}, // R2 clean fill
        {4'd5,  2'd1, 6'h05, 16'hAAAA, 1'b0, 16'h0000, 2'd0, 2'd0}, // R5 silent upgrade
        {4'd13, 2'd0, 6'h05, 16'h0000, 1'b0, 16'hAAAA, 2'd0, 2'd0}, // R13 read hit
        {4'd3,  2'd0, 6'h06, 16'h0000, 1'b1, 16'h1006, 2'd1, 2'd0}, // R3 shared fill
        {4'd3,  2'd1, 6'h06, 16'hBBBB, 1'b0, 16'h0000, 2'd1, 2'd2}, // R3 invalidate on write
        {4'd13, 2'd0, 6'h06, 16'h0000, 1'b0, 16'hBBBB, 2'd0, 2'd0}, // R13 read hit
        {4'd6,  2'd1, 6'h09, 16'hCCCC, 1'b0, 16'h0000, 2'd2, 2'd1}, // R6 write miss after writeback
        {4'd11, 2'd0, 6'h05, 16'h0000, 1'b0, 16'hAAAA, 2'd2, 2'd0}, // R11 dirty eviction
        {4'd11, 2'd0, 6'h09, 16'h0000, 1'b0, 16'hCCCC, 2'd1, 2'd0}, // R11 silent clean eviction
        {4'd7,  2'd2, 6'h0A, 16'h0000, 1'b0, 16'h100A, 2'd2, 2'd1}, // R7 ownership miss
        {4'd7,  2'd1, 6'h0A, 16'h1234, 1'b0, 16'h0000, 2'd0, 2'd0}  // R7 installed Exclusive
    };

    initial begin
        logic [DW-1:0] rd, sd;
        logic sh, wb;
        int ntx, cyc;
        for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + 16'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: quiet after reset, all lines Invalid
        chk(bus_valid == 1'b0 && cpu_ack == 1'b0, "R1 idle after reset", {bus_valid, cpu_ack}, 0);
        snoop(2'd0, 6'h00, sh, wb, sd);
        chk(sh == 1'b0 && wb == 1'b0, "R1 R12 snoop on empty cache", {sh, wb}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [48:0] v;
            v = VEC[i];
            shr_mode = v[20] ? 1 : 0;
            cpu_do(v[44:43], v[42:37], v[36:21], rd, ntx, cyc);
            shr_mode = 0;
            if (v[44:43] != 2'd1)
                chk(rd == v[19:4], $sformatf("R%0d row %0d data", v[48:45], i), rd, v[19:4]);
            chk(ntx == int'(v[3:2]), $sformatf("R%0d row %0d bus count", v[48:45], i), ntx, v[3:2]);
            if (v[3:2] != 2'd0)
                chk(last_cmd == v[1:0], $sformatf("R%0d row %0d last cmd", v[48:45], i), last_cmd, v[1:0]);
            else
                chk(cyc == 1, $sformatf("R13 row %0d one-cycle hit", i), cyc, 1);
        end
        // R11: last victim written back with its own address and data
        chk(wb_addr == 6'h06 && wb_data == 16'hBBBB, "R11 victim address/data", {wb_addr, wb_data}, {6'h06, 16'hBBBB});

        // R4: shared seen only after the sampling cycle still gives Exclusive
        shr_mode = 2;
        cpu_do(2'd0, 6'h03, 0, rd, ntx, cyc);
        shr_mode = 0;
        chk(rd == 16'h1003, "R4 fill data", rd, 16'h1003);
        cpu_do(2'd1, 6'h03, 16'h3333, rd, ntx, cyc);
        chk(ntx == 0, "R4 late shared ignored, write silent", ntx, 0);

        // R8: clean Exclusive line answers a snooped read, drops to Shared
        snoop(2'd0, 6'h09, sh, wb, sd);
        chk(sh == 1'b1 && wb == 1'b0 && sd == 16'hCCCC, "R8 clean snoop response", {sh, wb, sd}, {2'b10, 16'hCCCC});
        cpu_do(2'd1, 6'h09, 16'hD1D1, rd, ntx, cyc);
        chk(ntx == 1 && last_cmd == 2'd2, "R8 now Shared, write invalidates", {ntx[3:0], last_cmd}, {4'd1, 2'd2});

        // R9: Modified line flushes on a snooped read and becomes Shared
        snoop(2'd0, 6'h09, sh, wb, sd);
        chk(sh == 1'b1 && wb == 1'b1 && sd == 16'hD1D1, "R9 dirty snoop response", {sh, wb, sd}, {2'b11, 16'hD1D1});
        cpu_do(2'd1, 6'h09, 16'hE2E2, rd, ntx, cyc);
        chk(ntx == 1 && last_cmd == 2'd2, "R9 now Shared, write invalidates", {ntx[3:0], last_cmd}, {4'd1, 2'd2});

        // R10: snooped read-exclusive takes a Modified line away with its data
        snoop(2'd1, 6'h09, sh, wb, sd);
        chk(wb == 1'b1 && sd == 16'hE2E2, "R10 read-exclusive flush", {wb, sd}, {1'b1, 16'hE2E2});
        snoop(2'd0, 6'h09, sh, wb, sd);
        chk(sh == 1'b0 && wb == 1'b0, "R10 line gone after read-exclusive", {sh, wb}, 0);
        cpu_do(2'd0, 6'h09, 0, rd, ntx, cyc);
        chk(ntx == 1 && rd == 16'hE2E2, "R10 refetch after invalidation", {ntx[3:0], rd}, {4'd1, 16'hE2E2});

        // R12: snoops to another tag on the same line have no effect
        snoop(2'd0, 6'h0D, sh, wb, sd);
        chk(sh == 1'b0 && wb == 1'b0, "R12 other-tag snoop silent", {sh, wb}, 0);
        snoop(2'd2, 6'h0D, sh, wb, sd);
        cpu_do(2'd0, 6'h09, 0, rd, ntx, cyc);
        chk(ntx == 0 && rd == 16'hE2E2, "R12 line kept after other-tag invalidate", {ntx[3:0], rd}, {4'd0, 16'hE2E2});

        // R7: ownership fill from a peer's data lands in Exclusive
        peer_give = 1'b1; peer_val = 16'h7777;
        cpu_do(2'd2, 6'h04, 0, rd, ntx, cyc);
        peer_give = 1'b0;
        chk(rd == 16'h7777 && ntx == 1 && last_cmd == 2'd1, "R7 peer-supplied ownership", {rd, last_cmd}, {16'h7777, 2'd1});
        cpu_do(2'd1, 6'h04, 16'h4444, rd, ntx, cyc);
        chk(ntx == 0, "R7 Exclusive after ownership, write silent", ntx, 0);
        cpu_do(2'd2, 6'h04, 0, rd, ntx, cyc);
        chk(ntx == 0 && rd == 16'h4444, "R7 ownership hit on Modified", {ntx[3:0], rd}, {4'd0, 16'h4444});
        shr_mode = 1;
        cpu_do(2'd0, 6'h08, 0, rd, ntx, cyc);
        shr_mode = 0;
        chk(ntx == 2 && rd == 16'h1008, "R11 R3 dirty victim then shared fill", {ntx[3:0], rd}, {4'd2, 16'h1008});
        cpu_do(2'd2, 6'h08, 0, rd, ntx, cyc);
        chk(ntx == 1 && last_cmd == 2'd1 && rd == 16'h1008, "R7 ownership upgrade from Shared", {ntx[3:0], last_cmd}, {4'd1, 2'd1});
        cpu_do(2'd1, 6'h08, 16'h8888, rd, ntx, cyc);
        chk(ntx == 0, "R7 upgraded line is Exclusive", ntx, 0);

        // R10: invalidate on a Shared line
        snoop(2'd0, 6'h0A, sh, wb, sd);
        chk(sh == 1'b1 && wb == 1'b1 && sd == 16'h1234, "R9 dirty line shared", {sh, wb, sd}, {2'b11, 16'h1234});
        snoop(2'd2, 6'h0A, sh, wb, sd);
        cpu_do(2'd0, 6'h0A, 0, rd, ntx, cyc);
        chk(ntx == 1 && rd == 16'h1234, "R10 invalidate then refetch", {ntx[3:0], rd}, {4'd1, 16'h1234});

        finish_run();
    end
endmodule